// File: doc/BRIEF.md
# Cartridge bank-switching address mapper

This block sits between a 16-bit processor and a cartridge slot. It first forms the 20-bit linear address from a segment value and an offset, with the segment weighted by 16. It then decides which memory the linear address falls into: internal memory, the battery-backed SRAM window, one of two movable 64 KB ROM windows, or the large linear ROM window. For a cartridge access it produces a 26-bit physical address and asserts exactly one of ROM-select or SRAM-select. That physical address space covers up to 64 MB of ROM.

Four bank registers steer the windows. A host port writes them one at a time. The two small ROM windows can each be placed on any 64 KB page of ROM. The linear window picks a 1 MB slice of ROM. Because the window only spans linear addresses 0x40000 to 0xFFFFF, only the upper 768 KB of that slice is reachable. The mapping path is combinational from the address inputs and the current register contents. A register write becomes visible after the clock edge that captures it.

Top module: `cart_addr_mapper`

## Requirements
- R1: `lin_addr_o` equals (`seg_i` × 16 + `ofs_i`) modulo 2^20, so a sum above 0xFFFFF wraps to the bottom of the space.
- R2: For a linear address in 0x00000–0x0FFFF, both `rom_sel_o` and `sram_sel_o` are low and `phys_addr_o` is zero.
- R3: For a linear address in 0x10000–0x1FFFF, `sram_sel_o` is high, `rom_sel_o` is low, and `phys_addr_o` = {SRAM bank, lin[15:0]}.
- R4: For a linear address in 0x20000–0x2FFFF, `rom_sel_o` is high and `phys_addr_o` = {ROM page A bank (10 bits), lin[15:0]}.
- R5: For a linear address in 0x30000–0x3FFFF, `rom_sel_o` is high and `phys_addr_o` = {ROM page B bank (10 bits), lin[15:0]}.
- R6: For a linear address in 0x40000–0xFFFFF, `rom_sel_o` is high and `phys_addr_o` = {slice bank (6 bits), lin[19:0]}. Slice offsets below 0x40000 are never produced.
- R7: A write with `wr_en_i` high stores `wr_data_i` into the register chosen by `wr_sel_i`: 0 = SRAM bank, 1 = ROM page A, 2 = ROM page B, 3 = slice bank. The slice bank takes only `wr_data_i[5:0]`. The new value shapes the mapping from the capturing rising edge onward.
- R8: After reset every bank register is all-ones: 0x3FF for the SRAM and page banks, and 0x3F for the slice bank.
- R9: `rom_sel_o` and `sram_sel_o` are never high together.
- R10: While `wr_en_i` is low, `wr_sel_i` and `wr_data_i` have no effect on any bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seg_i | input | 16 | Segment value |
| ofs_i | input | 16 | Offset within the segment |
| wr_en_i | input | 1 | Bank register write enable |
| wr_sel_i | input | 2 | Bank register select (0 SRAM, 1 page A, 2 page B, 3 slice) |
| wr_data_i | input | 10 | Bank register write data |
| lin_addr_o | output | 20 | Linear address |
| phys_addr_o | output | 26 | Physical cartridge address |
| rom_sel_o | output | 1 | ROM access select |
| sram_sel_o | output | 1 | SRAM access select |

## Verification
The hardest cases to reach are the ones where the segment and offset addition carries across a region boundary or past the top of the 20-bit space. Examples are a segment of 0xFFFF with offset 0x0010 wrapping to 0x00000, and 0x0FFF with 0x0010 landing exactly on the first SRAM byte. The stimulus picks segment and offset pairs whose sum sits on each window edge. These pairs are applied after non-reset bank values have been written, so that a wrong bank or a wrong bit split shows in the upper physical bits.

// File: rtl/cam_pkg.sv
package cam_pkg;
  // Host write select codes
  typedef enum logic [1:0] {
    WSEL_SRAM = 2'd0,
    WSEL_PGA  = 2'd1,
    WSEL_PGB  = 2'd2,
    WSEL_SLC  = 2'd3
  } wsel_e;

  // Decoded target of a linear address
  typedef enum logic [2:0] {
    RG_INT  = 3'd0,
    RG_SRAM = 3'd1,
    RG_PGA  = 3'd2,
    RG_PGB  = 3'd3,
    RG_SLC  = 3'd4
  } region_e;
endpackage

// File: rtl/cam_lin_gen.sv
module cam_lin_gen #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LIN_AW = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFS_W-1:0]  ofs,
  output logic [LIN_AW-1:0] lin
);
  localparam int unsigned SHIFT = LIN_AW - SEG_W;

  logic [LIN_AW-1:0] seg_scaled;
  logic [LIN_AW-1:0] ofs_ext;

  always_comb begin
    seg_scaled = {seg, {SHIFT{1'b0}}};
    ofs_ext    = LIN_AW'(ofs);
    lin        = seg_scaled + ofs_ext;  // carry out of the top bit is dropped
  end
endmodule

// File: rtl/cam_bank_regs.sv
module cam_bank_regs #(
  parameter int unsigned BANK_W = 10,
  parameter int unsigned SLC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BANK_W-1:0] bank_sram,
  output logic [BANK_W-1:0] bank_pga,
  output logic [BANK_W-1:0] bank_pgb,
  output logic [SLC_W-1:0]  bank_slc
);
  localparam int unsigned NREG = 4;

  logic [BANK_W-1:0] q_r [NREG];
  logic [BANK_W-1:0] q_d [NREG];
  logic              ce  [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_comb begin
      ce[g]  = wr_en && (wr_sel == 2'(g));
      q_d[g] = ce[g] ? wr_data : q_r[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r[g] <= '1;
      else        q_r[g] <= q_d[g];
    end
  end

  assign bank_sram = q_r[cam_pkg::WSEL_SRAM];
  assign bank_pga  = q_r[cam_pkg::WSEL_PGA];
  assign bank_pgb  = q_r[cam_pkg::WSEL_PGB];
  assign bank_slc  = q_r[cam_pkg::WSEL_SLC][SLC_W-1:0];
endmodule

// File: rtl/cam_region_decode.sv
module cam_region_decode #(
  parameter int unsigned LIN_AW = 20
) (
  input  logic [LIN_AW-1:0]      lin,
  output cam_pkg::region_e       region
);
  import cam_pkg::*;
  localparam int unsigned NIB_W = LIN_AW - 16;

  logic [NIB_W-1:0] page;

  always_comb begin
    page = lin[LIN_AW-1:16];
    if (page == NIB_W'(0))      region = RG_INT;
    else if (page == NIB_W'(1)) region = RG_SRAM;
    else if (page == NIB_W'(2)) region = RG_PGA;
    else if (page == NIB_W'(3)) region = RG_PGB;
    else                        region = RG_SLC;
  end
endmodule

// File: rtl/cam_phys_mux.sv
module cam_phys_mux #(
  parameter int unsigned LIN_AW = 20,
  parameter int unsigned PHY_AW = 26,
  parameter int unsigned BANK_W = 10,
  parameter int unsigned SLC_W  = 6
) (
  input  cam_pkg::region_e   region,
  input  logic [LIN_AW-1:0]  lin,
  input  logic [BANK_W-1:0]  bank_sram,
  input  logic [BANK_W-1:0]  bank_pga,
  input  logic [BANK_W-1:0]  bank_pgb,
  input  logic [SLC_W-1:0]   bank_slc,
  output logic [PHY_AW-1:0]  phys,
  output logic               rom_sel,
  output logic               sram_sel
);
  import cam_pkg::*;

  always_comb begin
    phys     = '0;
    rom_sel  = 1'b0;
    sram_sel = 1'b0;
    unique case (region)
      RG_SRAM: begin
        sram_sel = 1'b1;
        phys     = PHY_AW'({bank_sram, lin[15:0]});
      end
      RG_PGA: begin
        rom_sel = 1'b1;
        phys    = PHY_AW'({bank_pga, lin[15:0]});
      end
      RG_PGB: begin
        rom_sel = 1'b1;
        phys    = PHY_AW'({bank_pgb, lin[15:0]});
      end
      RG_SLC: begin
        rom_sel = 1'b1;
        phys    = PHY_AW'({bank_slc, lin});
      end
      default: begin
        phys = '0;
      end
    endcase
  end
endmodule

// File: rtl/cart_addr_mapper.sv
module cart_addr_mapper #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned LIN_AW = 20,
  parameter int unsigned PHY_AW = 26
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEG_W-1:0]         seg_i,
  input  logic [OFS_W-1:0]         ofs_i,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_sel_i,
  input  logic [PHY_AW-16-1:0]     wr_data_i,
  output logic [LIN_AW-1:0]        lin_addr_o,
  output logic [PHY_AW-1:0]        phys_addr_o,
  output logic                     rom_sel_o,
  output logic                     sram_sel_o
);
  localparam int unsigned BANK_W = PHY_AW - 16;
  localparam int unsigned SLC_W  = PHY_AW - LIN_AW;

  // rst_n is expected to be released synchronously by the reset tree
  cam_pkg::region_e  region;
  logic [BANK_W-1:0] bank_sram;
  logic [BANK_W-1:0] bank_pga;
  logic [BANK_W-1:0] bank_pgb;
  logic [SLC_W-1:0]  bank_slc;

  cam_lin_gen #(.SEG_W(SEG_W), .OFS_W(OFS_W), .LIN_AW(LIN_AW)) u_lin (
    .seg (seg_i),
    .ofs (ofs_i),
    .lin (lin_addr_o)
  );

  cam_bank_regs #(.BANK_W(BANK_W), .SLC_W(SLC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .wr_sel    (wr_sel_i),
    .wr_data   (wr_data_i),
    .bank_sram (bank_sram),
    .bank_pga  (bank_pga),
    .bank_pgb  (bank_pgb),
    .bank_slc  (bank_slc)
  );

  cam_region_decode #(.LIN_AW(LIN_AW)) u_dec (
    .lin    (lin_addr_o),
    .region (region)
  );

  cam_phys_mux #(.LIN_AW(LIN_AW), .PHY_AW(PHY_AW), .BANK_W(BANK_W), .SLC_W(SLC_W)) u_mux (
    .region    (region),
    .lin       (lin_addr_o),
    .bank_sram (bank_sram),
    .bank_pga  (bank_pga),
    .bank_pgb  (bank_pgb),
    .bank_slc  (bank_slc),
    .phys      (phys_addr_o),
    .rom_sel   (rom_sel_o),
    .sram_sel  (sram_sel_o)
  );
endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
  parameter int unsigned LIN_AW = 20,
  parameter int unsigned PHY_AW = 26,
  parameter int unsigned BANK_W = 10,
  parameter int unsigned SLC_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [BANK_W-1:0] wr_data_i,
  input logic [LIN_AW-1:0] lin_addr_o,
  input logic [PHY_AW-1:0] phys_addr_o,
  input logic              rom_sel_o,
  input logic              sram_sel_o,
  input logic [BANK_W-1:0] bank_sram,
  input logic [BANK_W-1:0] bank_pga,
  input logic [BANK_W-1:0] bank_pgb,
  input logic [SLC_W-1:0]  bank_slc
);
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel_o && sram_sel_o)); // R9

  AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_addr_o[LIN_AW-1:16] == '0) |-> (!rom_sel_o && !sram_sel_o && phys_addr_o == '0)); // R2

  AST_SRAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_addr_o[LIN_AW-1:16] == 1) |-> (sram_sel_o && phys_addr_o[15:0] == lin_addr_o[15:0])); // R3

  AST_SLICE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_addr_o[LIN_AW-1:16] >= 4) |-> (rom_sel_o && phys_addr_o[LIN_AW-1:0] == lin_addr_o
                                        && phys_addr_o[PHY_AW-1:LIN_AW] == bank_slc)); // R6

  AST_PGA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en_i) && $past(wr_sel_i) == 2'd1) |-> (bank_pga == $past(wr_data_i))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en_i)) |-> ($stable(bank_sram) && $stable(bank_pga)
                                          && $stable(bank_pgb) && $stable(bank_slc))); // R10
endmodule

bind cart_addr_mapper cam_checker #(
  .LIN_AW(LIN_AW), .PHY_AW(PHY_AW), .BANK_W(BANK_W), .SLC_W(SLC_W)
) u_chk (.*);

// File: tb/cart_addr_mapper_test.sv
module cart_addr_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] seg_i, ofs_i;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [9:0]  wr_data_i;
  logic [19:0] lin_addr_o;
  logic [25:0] phys_addr_o;
  logic        rom_sel_o, sram_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [19:0] lin;
    logic [25:0] phys;
    logic        rom;
    logic        sram;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  // bench model of the bank registers
  logic [9:0] m_sram, m_pga, m_pgb;
  logic [5:0] m_slc;

  always #10 clk = ~clk;  // 50 MHz

  cart_addr_mapper uut (
    .clk(clk), .rst_n(rst_n), .seg_i(seg_i), .ofs_i(ofs_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .lin_addr_o(lin_addr_o), .phys_addr_o(phys_addr_o),
    .rom_sel_o(rom_sel_o), .sram_sel_o(sram_sel_o)
  );

  function automatic exp_t predict(logic [15:0] s, logic [15:0] o, string tag);
    exp_t e;
    logic [23:0] full;
    full   = {s, 4'h0} + {8'h00, o};
    e.lin  = full[19:0];
    e.tag  = tag;
    e.rom  = 1'b0;
    e.sram = 1'b0;
    e.phys = '0;
    if (e.lin < 20'h10000) begin
      e.phys = '0;
    end else if (e.lin < 20'h20000) begin
      e.sram = 1'b1; e.phys = {m_sram, e.lin[15:0]};
    end else if (e.lin < 20'h30000) begin
      e.rom = 1'b1;  e.phys = {m_pga, e.lin[15:0]};
    end else if (e.lin < 20'h40000) begin
      e.rom = 1'b1;  e.phys = {m_pgb, e.lin[15:0]};
    end else begin
      e.rom = 1'b1;  e.phys = {m_slc, e.lin};
    end
    return e;
  endfunction

  task automatic drive(logic [15:0] s, logic [15:0] o, string tag);
    @(posedge clk);
    #2;
    seg_i = s;
    ofs_i = o;
    sbq.push_back(predict(s, o, tag));
  endtask

  task automatic host_write(logic [1:0] sel, logic [9:0] data);
    @(posedge clk);
    #2;
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(posedge clk);
    #2;
    wr_en_i = 1'b0;
    case (sel)
      2'd0: m_sram = data;
      2'd1: m_pga  = data;
      2'd2: m_pgb  = data;
      default: m_slc = data[5:0];
    endcase
  endtask

  // monitor: compares once per cycle, away from the rising edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (lin_addr_o !== e.lin || phys_addr_o !== e.phys ||
          rom_sel_o !== e.rom || sram_sel_o !== e.sram) begin
        errors++;
        $display("FAIL %s: lin %h phys %h rom %b sram %b, expected lin %h phys %h rom %b sram %b",
                 e.tag, lin_addr_o, phys_addr_o, rom_sel_o, sram_sel_o,
                 e.lin, e.phys, e.rom, e.sram);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; seg_i = '0; ofs_i = '0;
    wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0;
    m_sram = 10'h3FF; m_pga = 10'h3FF; m_pgb = 10'h3FF; m_slc = 6'h3F;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // reset state (R8) and internal region (R2)
    drive(16'h0000, 16'h0000, "R2 reset internal zero");
    drive(16'h2000, 16'h1234, "R8 page A reset bank");
    drive(16'h3000, 16'h0001, "R8 page B reset bank");
    drive(16'h1000, 16'h0042, "R8 sram reset bank");
    drive(16'h4000, 16'h5678, "R8 slice reset bank");

    // bank writes (R7) and window mapping
    host_write(2'd2, 10'h068);
    drive(16'h3108, 16'h4240, "R5 R1 page B mapped");
    host_write(2'd1, 10'h2A5);
    drive(16'h2000, 16'hFFFF, "R4 page A top byte");
    drive(16'h1FFF, 16'h0010, "R4 page A first byte");
    host_write(2'd0, 10'h013);
    drive(16'h1000, 16'h0ABC, "R3 sram mapped");
    drive(16'h0FFF, 16'h0010, "R3 R1 sram first byte via carry");
    host_write(2'd3, 10'h3D5);
    drive(16'hF000, 16'hFFFF, "R6 R7 slice top byte, upper data bits dropped");
    drive(16'h4000, 16'h0000, "R6 slice lowest reachable");
    drive(16'h3FFF, 16'h000F, "R5 page B last byte");

    // ignored write inputs while enable is low (R10)
    @(posedge clk);
    #2 wr_en_i = 1'b0; wr_sel_i = 2'd1; wr_data_i = 10'h000;
    @(posedge clk);
    #2 wr_sel_i = 2'd3; wr_data_i = 10'h001;
    drive(16'h2000, 16'h0100, "R10 page A unchanged");
    drive(16'h5000, 16'h0000, "R10 slice unchanged");

    // wrap and internal edges (R1, R2, R9)
    drive(16'hFFFF, 16'h0010, "R1 wrap to zero");
    drive(16'h0000, 16'hFFFF, "R2 internal last byte");
    drive(16'hFFFF, 16'hFFFF, "R1 wrap into internal");
    drive(16'hFFFF, 16'h000F, "R9 top of space");

    repeat (3) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule